// File: doc/BRIEF.md
# Level-Qualified Interrupt Deglitcher

This block sits between a noisy device interrupt line and a host that receives an event strobe on every edge of that line. The device asks for service by driving its line high, so only a rising edge can carry a genuine request. Falling edges and glitches also produce strobes, and these must not reach the host as interrupts.

The raw line first passes through a two-flop synchronizer. When an edge strobe is accepted, the block runs qualification steps. Each step reads the synchronized line on two consecutive cycles and compares the two readings. If the readings match, the line has settled and its value decides the outcome. If they differ, another step is run. This repeats until the step budget taken from `retry_limit` is used up. A settled high level produces a one-cycle interrupt pulse. A settled low level, or an exhausted budget, discards the event and counts it in a saturating spurious-event counter, which a clear input resets. Strobes that arrive while a qualification is running are merged into it.

Top module: `irq_qualifier`

## Requirements
- R1: The raw pin reaches the qualification logic through exactly two flip-flops. As a result, a pin that rises in the same cycle as an accepted strobe gives a low first reading, and with a budget of one that event is discarded.
- R2: A strobe seen while idle starts a qualification and latches `retry_limit` as the step budget. Each step takes the synchronized pin on two consecutive cycles.
- R3: When both readings of a step are high, `irq_out` is high for exactly one cycle, the cycle after the second reading.
- R4: When both readings of a step are low, the event is discarded, `spur_count` rises by one, and `irq_out` stays low.
- R5: When the readings of a step differ, a new step follows while budget remains. After `retry_limit` differing steps, the event is discarded and counted.
- R6: With `retry_limit` equal to 0, an accepted strobe is discarded and counted one cycle after it is accepted, without sampling the pin.
- R7: Strobes that arrive while a qualification is running have no effect. One qualification yields at most one outcome.
- R8: `spur_count` saturates at its all-ones value.
- R9: `clr_spur` sets `spur_count` to 0 on the next edge and takes priority over a discard in the same cycle.
- R10: After reset, `irq_out` and `spur_count` are 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_raw | input | 1 | Asynchronous device interrupt line |
| edge_evt | input | 1 | Strobe raised for any edge of the line |
| retry_limit | input | LIMIT_W (4) | Maximum number of qualification steps per event |
| clr_spur | input | 1 | Clears the spurious-event counter |
| irq_out | output | 1 | One-cycle qualified interrupt pulse |
| spur_count | output | CW (8) | Saturating count of discarded events |

## Verification
The main function is driven with a steady high line, which must fire, and a steady low line, which must be counted. It is also driven with a line that toggles every cycle for the whole window, which separates budget exhaustion from settling. A line that toggles briefly and then holds high shows that a later step can still fire. A line that rises in the same cycle as the strobe exposes the synchronizer latency, because it is discarded with a budget of one and fires with a budget of two. A strobe held across a busy qualification shows merging. Zero budget, saturation and clear-versus-discard collisions cover the counter boundaries.

// File: rtl/irqq_pkg.sv
package irqq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD1  = 2'd1,
    ST_RD2  = 2'd2,
    ST_DROP = 2'd3
  } qstate_t;

  // Two readings of one step agree: the line is considered settled.
  function automatic logic readings_agree(input logic first_rd, input logic second_rd);
    return first_rd == second_rd;
  endfunction

endpackage

// File: rtl/irqq_sync2.sv
module irqq_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irqq_ctrl.sv
module irqq_ctrl
  import irqq_pkg::*;
#(
  parameter int LIMIT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pin_s,
  input  logic               edge_evt,
  input  logic [LIMIT_W-1:0] retry_limit,
  output logic               fire_evt,
  output logic               drop_evt,
  output logic               busy,
  output logic               first_rd
);
  localparam logic [LIMIT_W-1:0] ONE = LIMIT_W'(1);

  qstate_t            state, state_nxt;
  logic [LIMIT_W-1:0] tries, tries_nxt;

  always_comb begin
    state_nxt = state;
    tries_nxt = tries;
    fire_evt  = 1'b0;
    drop_evt  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (edge_evt) begin
          if (retry_limit == '0) begin
            state_nxt = ST_DROP;
          end else begin
            state_nxt = ST_RD1;
            tries_nxt = retry_limit;
          end
        end
      end
      ST_RD1: state_nxt = ST_RD2;
      ST_RD2: begin
        if (readings_agree(first_rd, pin_s)) begin
          fire_evt  = pin_s;
          drop_evt  = !pin_s;
          state_nxt = ST_IDLE;
        end else if (tries <= ONE) begin
          drop_evt  = 1'b1;
          state_nxt = ST_IDLE;
        end else begin
          tries_nxt = tries - ONE;
          state_nxt = ST_RD1;
        end
      end
      ST_DROP: begin
        drop_evt  = 1'b1;
        state_nxt = ST_IDLE;
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      tries    <= '0;
      first_rd <= 1'b0;
    end else begin
      state <= state_nxt;
      tries <= tries_nxt;
      if (state == ST_RD1) first_rd <= pin_s;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/irqq_spur_cnt.sv
module irqq_spur_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  function automatic logic [CW-1:0] sat_next(input logic [CW-1:0] cur,
                                             input logic clr_i, input logic inc_i);
    if (clr_i)                  return '0;
    if (inc_i && (cur != TOP))  return cur + CW'(1);
    return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= sat_next(count, clr, inc);
  end
endmodule

// File: rtl/irq_qualifier.sv
module irq_qualifier #(
  parameter int LIMIT_W = 4,
  parameter int CW      = 8,
  parameter int SYNC_N  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pin_raw,
  input  logic               edge_evt,
  input  logic [LIMIT_W-1:0] retry_limit,
  input  logic               clr_spur,
  output logic               irq_out,
  output logic [CW-1:0]      spur_count
);
  logic pin_s;
  logic fire_evt;
  logic drop_evt;
  logic busy;
  logic first_rd;

  irqq_sync2 #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_s)
  );

  irqq_ctrl #(.LIMIT_W(LIMIT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .edge_evt(edge_evt),
    .retry_limit(retry_limit), .fire_evt(fire_evt), .drop_evt(drop_evt),
    .busy(busy), .first_rd(first_rd)
  );

  irqq_spur_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr_spur), .inc(drop_evt), .count(spur_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= fire_evt;
  end
endmodule

// File: rtl/irqq_chk.sv
module irqq_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_out,
  input logic [CW-1:0] spur_count,
  input logic          clr_spur,
  input logic          fire_evt,
  input logic          drop_evt,
  input logic          busy,
  input logic          first_rd,
  input logic          pin_s
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  // R3
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |=> !irq_out);

  // R3
  irq_from_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(fire_evt));

  // R3
  fire_needs_high_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_evt |-> (first_rd && pin_s && busy));

  // R7
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fire_evt, drop_evt}));

  // R7
  outcome_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_evt || drop_evt) |=> !busy);

  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spur_count == TOP && !clr_spur) |=> spur_count == TOP);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_spur |=> (spur_count == $past(spur_count)) ||
                  (spur_count == $past(spur_count) + CW'(1)));

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_spur |=> spur_count == '0);
endmodule

bind irq_qualifier irqq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .spur_count(spur_count),
  .clr_spur(clr_spur), .fire_evt(fire_evt), .drop_evt(drop_evt),
  .busy(busy), .first_rd(first_rd), .pin_s(pin_s)
);

// File: tb/sim_irq_qualifier.sv
`timescale 1ns/1ps
module sim_irq_qualifier;
  localparam int LW = 4;
  localparam int CW = 8;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_raw = 1'b0;
  logic edge_evt = 1'b0;
  logic [LW-1:0] retry_limit = LW'(10);
  logic clr_spur = 1'b0;
  logic irq_out;
  logic [CW-1:0] spur_count;

  int n_chk = 0;
  int n_bad = 0;
  int irq_seen = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_qualifier #(.LIMIT_W(LW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .edge_evt(edge_evt),
    .retry_limit(retry_limit), .clr_spur(clr_spur),
    .irq_out(irq_out), .spur_count(spur_count)
  );

  // Behavioural reference: the pin delay is a queue, the qualification is a
  // phase counter with a budget counter.
  int pin_q[$] = '{0, 0};
  int phase = 0;      // 0 idle, 1 first read, 2 second read, 3 drop at once
  int budget = 0;
  int first_v = 0;
  int m_irq = 0;
  int m_cnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      pin_q = '{0, 0}; phase = 0; budget = 0; first_v = 0; m_irq = 0; m_cnt = 0;
    end else begin
      int seen;
      bit ok_fire;
      bit discard;
      seen = pin_q[1];
      ok_fire = 0; discard = 0;
      if (phase == 0) begin
        if (edge_evt) begin
          if (retry_limit == 0) phase = 3;
          else begin phase = 1; budget = retry_limit; end
        end
      end else if (phase == 1) begin
        first_v = seen; phase = 2;
      end else if (phase == 2) begin
        if (seen == first_v) begin
          if (seen == 1) ok_fire = 1; else discard = 1;
          phase = 0;
        end else begin
          budget = budget - 1;
          if (budget <= 0) begin discard = 1; phase = 0; end
          else phase = 1;
        end
      end else begin
        discard = 1; phase = 0;
      end
      m_irq = ok_fire ? 1 : 0;
      if (clr_spur) m_cnt = 0;
      else if (discard && m_cnt < MAXC) m_cnt = m_cnt + 1;
      void'(pin_q.pop_back());
      pin_q.push_front(pin_raw ? 1 : 0);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference (R3, R4, R5, R6, R7).
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R3 irq_out vs model", int'(irq_out), m_irq);
      chk("R4 spur_count vs model", int'(spur_count), m_cnt);
      if (irq_out) irq_seen++;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk) edge_evt = 1'b1;
    @(negedge clk) edge_evt = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int i0, c0;
    cyc(4);
    @(negedge clk) rst_n = 1'b1;
    // R10 reset state
    chk("R10 irq after reset", int'(irq_out), 0);
    chk("R10 count after reset", int'(spur_count), 0);

    // R3 clean high level
    pin_raw = 1'b1; cyc(4);
    i0 = irq_seen; c0 = int'(spur_count);
    strobe(); cyc(10);
    chk("R3 clean rise fires once", irq_seen - i0, 1);
    chk("R3 clean rise not counted", int'(spur_count), c0);

    // R4 settled low
    pin_raw = 1'b0; cyc(4);
    i0 = irq_seen; c0 = int'(spur_count);
    strobe(); cyc(10);
    chk("R4 falling edge counted", int'(spur_count), c0 + 1);
    chk("R4 falling edge no irq", irq_seen - i0, 0);

    // R6 zero budget with high pin
    pin_raw = 1'b1; retry_limit = '0; cyc(4);
    i0 = irq_seen; c0 = int'(spur_count);
    strobe(); cyc(6);
    chk("R6 zero budget discards", int'(spur_count), c0 + 1);
    chk("R6 zero budget no irq", irq_seen - i0, 0);

    // R5 line toggling throughout, budget 3
    retry_limit = LW'(3);
    i0 = irq_seen; c0 = int'(spur_count);
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      pin_raw = ~pin_raw;
      edge_evt = (k == 4);
    end
    edge_evt = 1'b0; pin_raw = 1'b0; cyc(4);
    chk("R5 unstable line exhausts budget", int'(spur_count), c0 + 1);
    chk("R5 unstable line no irq", irq_seen - i0, 0);

    // R5 line toggles then settles high, budget 10
    retry_limit = LW'(10);
    i0 = irq_seen; c0 = int'(spur_count);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      pin_raw = ~pin_raw;
      edge_evt = (k == 1);
    end
    @(negedge clk) pin_raw = 1'b1; edge_evt = 1'b0;
    cyc(24);
    chk("R5 settled after retries fires", irq_seen - i0, 1);
    chk("R5 settled after retries not counted", int'(spur_count), c0);

    // R7 strobe held across a running qualification
    i0 = irq_seen; c0 = int'(spur_count);
    @(negedge clk) edge_evt = 1'b1;
    cyc(2);
    @(negedge clk) edge_evt = 1'b0;
    cyc(8);
    chk("R7 merged strobes fire once", irq_seen - i0, 1);
    chk("R7 merged strobes not counted", int'(spur_count), c0);

    // R1 pin rises with the strobe: budget 1 discards, budget 2 fires
    pin_raw = 1'b0; retry_limit = LW'(1); cyc(5);
    i0 = irq_seen; c0 = int'(spur_count);
    @(negedge clk) pin_raw = 1'b1; edge_evt = 1'b1;
    @(negedge clk) edge_evt = 1'b0;
    cyc(8);
    chk("R1 sync latency budget 1 discards", int'(spur_count), c0 + 1);
    chk("R1 sync latency budget 1 no irq", irq_seen - i0, 0);
    pin_raw = 1'b0; retry_limit = LW'(2); cyc(5);
    i0 = irq_seen; c0 = int'(spur_count);
    @(negedge clk) pin_raw = 1'b1; edge_evt = 1'b1;
    @(negedge clk) edge_evt = 1'b0;
    cyc(8);
    chk("R2 budget 2 second step fires", irq_seen - i0, 1);
    chk("R2 budget 2 not counted", int'(spur_count), c0);

    // R9 clear wins over concurrent discards
    retry_limit = '0;
    @(negedge clk) clr_spur = 1'b1; edge_evt = 1'b1;
    cyc(6);
    chk("R9 clear beats discard", int'(spur_count), 0);
    @(negedge clk) clr_spur = 1'b0; edge_evt = 1'b0;
    cyc(3);

    // R8 saturation
    @(negedge clk) edge_evt = 1'b1;
    cyc(2 * MAXC + 60);
    @(negedge clk) edge_evt = 1'b0;
    cyc(4);
    chk("R8 counter saturates", int'(spur_count), MAXC);

    // R9 plain clear
    @(negedge clk) clr_spur = 1'b1;
    @(negedge clk) clr_spur = 1'b0;
    chk("R9 clear to zero", int'(spur_count), 0);
    cyc(3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule